// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single DMA channel that shuttles data between memory and one fixed device address. Two descriptors, called A and B, each hold a start address and a byte count. Software loads a descriptor and then arms it by setting that buffer's start bit together with run. The channel works through the armed descriptors in alternation, and a buffer-in-use bit records which descriptor is served next. An 8-bit status register can be read at all times. Software changes it only through a write-one-to-set port and a write-one-to-clear port.

A 32-bit configuration word supplies the device side of each transfer: the device address, the device select, the unit width, the burst length and the byte order. Work proceeds in bursts. Each burst opens with one request on the device request channel, followed by up to 4 or 8 unit requests on the memory request channel. Both channels are valid/ready. A raised valid stays high, with its payload held, until ready is seen. Back-pressure on either channel only stalls the channel and never drops a request. A memory fault returned with a handshake is latched as a sticky error. One interrupt line reports completion and errors.

Top module: `dbuf_dma_chan`

## Requirements
- R1: Status bits: 0 run, 1 interrupt enable, 2 error, 3 done A, 4 start A, 5 done B, 6 start B, 7 buffer-in-use (0 selects A, 1 selects B). A one on the set port sets the matching bit and a one on the clear port clears it. Zero bits leave the register unchanged. If one bit is written on both ports in the same cycle, the clear wins.
- R2: When run and the selected buffer's start bit are set, the channel issues memory requests beginning at that buffer's start address. The address rises by the bytes moved on each accepted unit, and the buffer's count falls by the same amount.
- R3: Configuration word: bits 31:8 device address, bits 7:4 device select, bit 3 unit width (0 gives 1 byte, 1 gives 2 bytes), bit 2 burst length (0 gives 4 units, 1 gives 8 units), bit 1 big-endian. Every burst starts with exactly one device request that carries these fields. A device request and a memory request are never offered in the same cycle.
- R4: When a buffer's count reaches zero, its start bit clears, its done bit sets, and buffer-in-use switches to the other buffer.
- R5: With run, start A and start B all set, the channel serves both buffers back to back. It serves the one selected by buffer-in-use first and needs no software action between them.
- R6: If the buffer selected by buffer-in-use is not armed, no request is issued, even when the other buffer is armed.
- R7: The interrupt output is high exactly while interrupt enable is set and at least one of done A, done B or error is set.
- R8: An accepted memory request with the fault input high sets error and clears the active buffer's start bit. It does not set done, and it leaves that buffer's count unchanged. Error stays set until software clears it.
- R9: A buffer whose low address byte plus count exceeds 256 is refused when it is armed. Error sets and its start bit clears, and no request is issued.
- R10: An armed buffer with count zero completes at once as in R4, with no request.
- R11: Clearing run pauses the channel. A request already offered is still completed, but no new request is raised until run is set again. The descriptor state is kept and the transfer resumes where it stopped.
- R12: A valid on either request channel that is not yet accepted stays high in the next cycle, and the memory address is held.
- R13: When a 2-byte transfer has one byte left, the final unit moves a single byte, signalled by a memory size of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sts_set_we | input | 1 | Set-port write strobe |
| sts_set_data | input | 8 | Bits to set |
| sts_clr_we | input | 1 | Clear-port write strobe |
| sts_clr_data | input | 8 | Bits to clear |
| sts_q | output | 8 | Status register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_q | output | 32 | Configuration register |
| desc_we | input | 1 | Descriptor write strobe |
| desc_sel | input | 1 | Descriptor to write (0 A, 1 B) |
| desc_addr | input | AW | Start address to load |
| desc_count | input | CW | Byte count to load |
| count_a | output | CW | Remaining bytes, buffer A |
| count_b | output | CW | Remaining bytes, buffer B |
| dev_req_valid | output | 1 | Device burst request valid |
| dev_req_ready | input | 1 | Device burst request accepted |
| dev_req_addr | output | 24 | Device address |
| dev_req_sel | output | 4 | Device select |
| dev_req_units | output | 4 | Nominal units in the burst (4 or 8) |
| dev_req_bigend | output | 1 | Big-endian byte order |
| mem_req_valid | output | 1 | Memory unit request valid |
| mem_req_ready | input | 1 | Memory unit request accepted |
| mem_req_addr | output | AW | Memory byte address |
| mem_req_size | output | 1 | Unit size (0 one byte, 1 two bytes) |
| mem_fault | input | 1 | Fault for the unit accepted this cycle |
| irq | output | 1 | Interrupt |

## Verification
The checks assume a few things about software. The configuration word and a descriptor are not rewritten while their buffer is armed. An error clear on the clear port does not coincide with a faulting handshake. The fault input counts only in a cycle where a memory handshake takes place. The bench changes configuration and descriptors only while the channel is idle, clears status only between transfers, and holds the fault input steady for a whole transfer. Its ready inputs stay high except in the pause sequence, where the memory ready is held low on purpose to exercise R11 and R12.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;
  localparam int ST_RUN     = 0;
  localparam int ST_IE      = 1;
  localparam int ST_ERR     = 2;
  localparam int ST_DONE_A  = 3;
  localparam int ST_START_A = 4;
  localparam int ST_DONE_B  = 5;
  localparam int ST_START_B = 6;
  localparam int ST_BIU     = 7;
  localparam int STW        = 8;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_DEV  = 2'd1,
    ENG_MEM  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/dbuf_dma_status.sv
module dbuf_dma_status
  import dbuf_dma_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_we,
  input  logic [STW-1:0] set_data,
  input  logic           clr_we,
  input  logic [STW-1:0] clr_data,
  input  logic           ev_fire,
  input  logic           ev_ok,
  input  logic           ev_sel,
  output logic [STW-1:0] sts_q
);
  logic [STW-1:0] nxt;

  always_comb begin
    nxt = sts_q;
    if (set_we) nxt = nxt | set_data;
    if (clr_we) nxt = nxt & ~clr_data;
    if (ev_fire) begin
      if (ev_sel) begin
        nxt[ST_START_B] = 1'b0;
        if (ev_ok) nxt[ST_DONE_B] = 1'b1;
      end else begin
        nxt[ST_START_A] = 1'b0;
        if (ev_ok) nxt[ST_DONE_A] = 1'b1;
      end
      if (!ev_ok) nxt[ST_ERR] = 1'b1;
      nxt[ST_BIU] = ~ev_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= nxt;
  end
endmodule

// File: rtl/dbuf_dma_desc.sv
module dbuf_dma_desc #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [AW-1:0]        wr_addr,
  input  logic [CW-1:0]        wr_cnt,
  input  logic                 adv_en,
  input  logic                 adv_sel,
  input  logic [1:0]           adv_step,
  output logic [1:0][AW-1:0]   addr_q,
  output logic [1:0][CW-1:0]   cnt_q
);
  localparam int NBUF = 2;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
      end else if (wr_en && (wr_sel == 1'(g))) begin
        addr_q[g] <= wr_addr;
        cnt_q[g]  <= wr_cnt;
      end else if (adv_en && (adv_sel == 1'(g))) begin
        addr_q[g] <= addr_q[g] + AW'(adv_step);
        cnt_q[g]  <= cnt_q[g] - CW'(adv_step);
      end
    end
  end
endmodule

// File: rtl/dbuf_dma_engine.sv
module dbuf_dma_engine
  import dbuf_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16   // at least 9 so a full 256-byte buffer fits
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               start_a,
  input  logic               start_b,
  input  logic               biu,
  input  logic               halfw,
  input  logic               burst8,
  input  logic [1:0][AW-1:0] buf_addr,
  input  logic [1:0][CW-1:0] buf_cnt,
  input  logic               dev_ready,
  input  logic               mem_ready,
  input  logic               mem_fault,
  output logic               dev_valid,
  output logic               mem_valid,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_size,
  output logic               adv_en,
  output logic [1:0]         adv_step,
  output logic               ev_fire,
  output logic               ev_ok,
  output logic               ev_sel
);
  localparam int SW   = CW + 1;
  localparam int PAGE = 256;

  eng_state_t st;
  logic       cur, hold;
  logic [3:0] units;

  logic          sel, armed, go, over, last, dev_hs, mem_hs;
  logic [CW-1:0] cnt_sel, unit;
  logic [AW-1:0] addr_sel;
  logic [1:0]    step;
  logic [SW-1:0] span;

  always_comb begin
    sel      = (st == ENG_IDLE) ? biu : cur;
    armed    = sel ? start_b : start_a;
    cnt_sel  = buf_cnt[sel];
    addr_sel = buf_addr[sel];
    unit     = halfw ? CW'(2) : CW'(1);
    step     = (cnt_sel < unit) ? 2'd1 : (halfw ? 2'd2 : 2'd1);
    span     = SW'(addr_sel[7:0]) + SW'(cnt_sel);
    over     = span > SW'(PAGE);
    go       = hold | (run & armed);
    dev_valid = (st == ENG_DEV) && go;
    mem_valid = (st == ENG_MEM) && go;
    dev_hs   = dev_valid && dev_ready;
    mem_hs   = mem_valid && mem_ready;
    last     = cnt_sel == CW'(step);
    mem_addr = addr_sel;
    mem_size = step == 2'd2;
    adv_en   = mem_hs && !mem_fault;
    adv_step = step;
    ev_sel   = sel;
    ev_fire  = 1'b0;
    ev_ok    = 1'b0;
    if (st == ENG_IDLE && run && armed) begin
      if (over) begin
        ev_fire = 1'b1;
      end else if (cnt_sel == '0) begin
        ev_fire = 1'b1;
        ev_ok   = 1'b1;
      end
    end
    if (mem_hs) begin
      if (mem_fault) begin
        ev_fire = 1'b1;
      end else if (last) begin
        ev_fire = 1'b1;
        ev_ok   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ENG_IDLE;
      cur   <= 1'b0;
      hold  <= 1'b0;
      units <= '0;
    end else begin
      hold <= (dev_valid && !dev_ready) || (mem_valid && !mem_ready);
      unique case (st)
        ENG_IDLE: begin
          if (run && armed && !over && cnt_sel != '0) begin
            st  <= ENG_DEV;
            cur <= sel;
          end
        end
        ENG_DEV: begin
          if (dev_hs) begin
            st    <= ENG_MEM;
            units <= burst8 ? 4'd8 : 4'd4;
          end else if (!go && !armed) begin
            st <= ENG_IDLE;
          end
        end
        ENG_MEM: begin
          if (mem_hs) begin
            if (mem_fault || last) st <= ENG_IDLE;
            else if (units == 4'd1) st <= ENG_DEV;
            else units <= units - 4'd1;
          end else if (!go && !armed) begin
            st <= ENG_IDLE;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sts_set_we,
  input  logic [7:0]    sts_set_data,
  input  logic          sts_clr_we,
  input  logic [7:0]    sts_clr_data,
  output logic [7:0]    sts_q,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_q,
  input  logic          desc_we,
  input  logic          desc_sel,
  input  logic [AW-1:0] desc_addr,
  input  logic [CW-1:0] desc_count,
  output logic [CW-1:0] count_a,
  output logic [CW-1:0] count_b,
  output logic          dev_req_valid,
  input  logic          dev_req_ready,
  output logic [23:0]   dev_req_addr,
  output logic [3:0]    dev_req_sel,
  output logic [3:0]    dev_req_units,
  output logic          dev_req_bigend,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_size,
  input  logic          mem_fault,
  output logic          irq
);
  logic [1:0][AW-1:0] buf_addr;
  logic [1:0][CW-1:0] buf_cnt;
  logic               adv_en, ev_fire, ev_ok, ev_sel;
  logic [1:0]         adv_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  dbuf_dma_status i_status (
    .clk, .rst_n,
    .set_we(sts_set_we), .set_data(sts_set_data),
    .clr_we(sts_clr_we), .clr_data(sts_clr_data),
    .ev_fire, .ev_ok, .ev_sel,
    .sts_q
  );

  dbuf_dma_desc #(.AW(AW), .CW(CW)) i_desc (
    .clk, .rst_n,
    .wr_en(desc_we), .wr_sel(desc_sel), .wr_addr(desc_addr), .wr_cnt(desc_count),
    .adv_en, .adv_sel(ev_sel), .adv_step,
    .addr_q(buf_addr), .cnt_q(buf_cnt)
  );

  dbuf_dma_engine #(.AW(AW), .CW(CW)) i_engine (
    .clk, .rst_n,
    .run(sts_q[ST_RUN]), .start_a(sts_q[ST_START_A]), .start_b(sts_q[ST_START_B]),
    .biu(sts_q[ST_BIU]), .halfw(cfg_q[3]), .burst8(cfg_q[2]),
    .buf_addr, .buf_cnt,
    .dev_ready(dev_req_ready), .mem_ready(mem_req_ready), .mem_fault,
    .dev_valid(dev_req_valid), .mem_valid(mem_req_valid),
    .mem_addr(mem_req_addr), .mem_size(mem_req_size),
    .adv_en, .adv_step, .ev_fire, .ev_ok, .ev_sel
  );

  assign count_a        = buf_cnt[0];
  assign count_b        = buf_cnt[1];
  assign dev_req_addr   = cfg_q[31:8];
  assign dev_req_sel    = cfg_q[7:4];
  assign dev_req_units  = cfg_q[2] ? 4'd8 : 4'd4;
  assign dev_req_bigend = cfg_q[1];
  assign irq = sts_q[ST_IE] &
               (sts_q[ST_DONE_A] | sts_q[ST_DONE_B] | sts_q[ST_ERR]);
endmodule

// File: rtl/dbuf_dma_chk.sv
module dbuf_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sts_set_we,
  input logic [7:0]    sts_set_data,
  input logic          sts_clr_we,
  input logic [7:0]    sts_clr_data,
  input logic [7:0]    sts_q,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          dev_req_valid,
  input logic          dev_req_ready,
  input logic          mem_fault,
  input logic          irq
);
  p_set_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sts_set_we && sts_set_data[0] && !(sts_clr_we && sts_clr_data[0]) |=> sts_q[0]);

  p_clear_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr_we && sts_clr_data[1] |=> !sts_q[1]);

  p_one_channel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && dev_req_valid));

  p_irq_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[1] && sts_q[2] |-> irq);

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_q[1] |-> !irq);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[2] && !(sts_clr_we && sts_clr_data[2]) |=> sts_q[2]);

  p_fault_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_fault && !(sts_clr_we && sts_clr_data[2])
    |=> sts_q[2]);

  p_new_req_needs_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> sts_q[0]);

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_dev_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_valid && !dev_req_ready |=> dev_req_valid);
endmodule

bind dbuf_dma_chan dbuf_dma_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .sts_set_we(sts_set_we), .sts_set_data(sts_set_data),
  .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
  .sts_q(sts_q),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr),
  .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
  .mem_fault(mem_fault), .irq(irq)
);

// File: tb/test_dbuf_dma_chan.sv
module test_dbuf_dma_chan;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int NV = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic sts_set_we = 0, sts_clr_we = 0, cfg_we = 0, desc_we = 0, desc_sel = 0;
  logic [7:0] sts_set_data = 0, sts_clr_data = 0, sts_q;
  logic [31:0] cfg_wdata = 0, cfg_q;
  logic [AW-1:0] desc_addr = 0, mem_req_addr;
  logic [CW-1:0] desc_count = 0, count_a, count_b;
  logic dev_req_valid, dev_req_ready = 1'b1, dev_req_bigend;
  logic [23:0] dev_req_addr;
  logic [3:0] dev_req_sel, dev_req_units;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_req_size, mem_fault = 1'b0, irq;

  dbuf_dma_chan #(.AW(AW), .CW(CW)) i_dbuf_dma_chan (.*);

  // vectors: address, count, width, burst, fault | mem beats, dev beats, error
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h2010, 32'h3000, 32'h40F0,
                                          32'h40F1, 32'h5000, 32'h6000, 32'h7020};
  localparam int V_CNT  [NV] = '{16, 10, 7, 16, 16, 0, 8, 32};
  localparam bit V_W    [NV] = '{0, 1, 1, 0, 0, 0, 0, 1};
  localparam bit V_B    [NV] = '{0, 1, 0, 1, 0, 0, 0, 1};
  localparam bit V_FLT  [NV] = '{0, 0, 0, 0, 0, 0, 1, 0};
  localparam int V_MEM  [NV] = '{16, 5, 4, 16, 0, 0, 1, 16};
  localparam int V_DEV  [NV] = '{4, 1, 1, 2, 0, 0, 1, 2};
  localparam bit V_ERR  [NV] = '{0, 0, 0, 0, 1, 0, 1, 0};

  int n_chk = 0, n_bad = 0, cyc = 0;
  int mem_beats = 0, dev_beats = 0, valid_cyc = 0;
  logic got_first = 0, last_size = 0, seen_be = 0;
  logic [31:0] first_addr = 0, last_addr = 0;
  logic [23:0] seen_dev = 0;
  logic [3:0] seen_sel = 0, seen_units = 0;

  always @(negedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      if (!got_first) first_addr = mem_req_addr;
      got_first = 1'b1;
      last_addr = mem_req_addr;
      last_size = mem_req_size;
      mem_beats++;
    end
    if (dev_req_valid && dev_req_ready) begin
      dev_beats++;
      seen_dev = dev_req_addr; seen_sel = dev_req_sel;
      seen_units = dev_req_units; seen_be = dev_req_bigend;
    end
    if (dev_req_valid || mem_req_valid) valid_cyc++;
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual %0d cycles expected under 100000", cyc);
      report();
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sts_wr(input logic [7:0] s, input logic [7:0] c);
    @(posedge clk); #1;
    sts_set_we = 1; sts_set_data = s; sts_clr_we = 1; sts_clr_data = c;
    @(posedge clk); #1;
    sts_set_we = 0; sts_clr_we = 0; sts_set_data = 0; sts_clr_data = 0;
  endtask

  task automatic cfg_wr(input logic [31:0] v);
    @(posedge clk); #1; cfg_we = 1; cfg_wdata = v;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic desc_wr(input logic s, input logic [31:0] a, input int n);
    @(posedge clk); #1; desc_we = 1; desc_sel = s; desc_addr = a; desc_count = CW'(n);
    @(posedge clk); #1; desc_we = 0;
  endtask

  task automatic clear_mon();
    @(negedge clk);
    mem_beats = 0; dev_beats = 0; valid_cyc = 0; got_first = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if ((sts_q & 8'h50) == 8'h00) break;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset status", 32'(sts_q), 32'h0);
    chk("R7", "reset irq", 32'(irq), 32'h0);
    chk("R12", "reset mem valid", 32'(mem_req_valid), 32'h0);
    chk("R3", "reset dev valid", 32'(dev_req_valid), 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      sts_wr(8'h00, 8'hFF);
      cfg_wr({24'h80A05A, 4'h5, V_W[i], V_B[i], 1'b1, 1'b0});
      desc_wr(1'b0, V_ADDR[i], V_CNT[i]);
      mem_fault = V_FLT[i];
      clear_mon();
      sts_wr(8'h11, 8'h00);
      wait_idle();
      mem_fault = 1'b0;
      chk("R2", $sformatf("vec%0d mem beats", i), 32'(mem_beats), 32'(V_MEM[i]));
      chk("R3", $sformatf("vec%0d dev beats", i), 32'(dev_beats), 32'(V_DEV[i]));
      if (V_ERR[i]) begin
        // R8 fault / R9 boundary: error, no done, biu moves to B
        chk("R8", $sformatf("vec%0d status", i), 32'(sts_q), 32'h85);
        chk("R9", $sformatf("vec%0d count kept", i), 32'(count_a), 32'(V_CNT[i]));
      end else begin
        // R4 / R10 completion
        chk("R4", $sformatf("vec%0d status", i), 32'(sts_q), 32'h89);
        chk("R10", $sformatf("vec%0d count", i), 32'(count_a), 32'h0);
      end
      if (V_MEM[i] > 0)
        chk("R2", $sformatf("vec%0d first addr", i), first_addr, V_ADDR[i]);
      if (V_DEV[i] > 0) begin
        chk("R3", $sformatf("vec%0d dev fields", i),
            {seen_dev, seen_sel, seen_units},
            {24'h80A05A, 4'h5, (V_B[i] ? 4'd8 : 4'd4)});
        chk("R3", $sformatf("vec%0d bigend", i), 32'(seen_be), 32'h1);
      end
      if (V_MEM[i] > 0 && !V_FLT[i])
        chk("R13", $sformatf("vec%0d last size", i), 32'(last_size),
            32'(V_W[i] && (V_CNT[i] % 2 == 0)));
    end

    // R1 set/clear port behaviour
    sts_wr(8'h00, 8'hFF);
    sts_wr(8'h02, 8'h00);
    @(negedge clk); chk("R1", "set ie", 32'(sts_q), 32'h02);
    sts_wr(8'h00, 8'h00);
    @(negedge clk); chk("R1", "zero writes ignored", 32'(sts_q), 32'h02);
    sts_wr(8'h80, 8'h00);
    @(negedge clk); chk("R1", "set biu", 32'(sts_q), 32'h82);
    sts_wr(8'h02, 8'h82);
    @(negedge clk); chk("R1", "clear wins", 32'(sts_q), 32'h00);

    // R6 waiting on unarmed selected buffer
    cfg_wr(32'h0000_0000);
    desc_wr(1'b1, 32'hA000, 4);
    clear_mon();
    sts_wr(8'h41, 8'h00);
    repeat (20) @(negedge clk);
    chk("R6", "no request", 32'(valid_cyc), 32'h0);
    chk("R6", "status unchanged", 32'(sts_q), 32'h41);
    sts_wr(8'h00, 8'hFF);

    // R5 both buffers armed
    desc_wr(1'b0, 32'h8000, 8);
    desc_wr(1'b1, 32'h8100, 4);
    clear_mon();
    sts_wr(8'h51, 8'h00);
    @(negedge clk); chk("R5", "fully occupied", 32'(sts_q), 32'h51);
    wait_idle();
    chk("R5", "both done", 32'(sts_q), 32'h29);
    chk("R5", "beats", 32'(mem_beats), 32'd12);
    chk("R5", "A first", first_addr, 32'h8000);
    chk("R5", "B last", last_addr, 32'h8103);

    // R7 interrupt
    chk("R7", "masked", 32'(irq), 32'h0);
    sts_wr(8'h02, 8'h00);
    @(negedge clk); chk("R7", "done raises", 32'(irq), 32'h1);
    sts_wr(8'h00, 8'h28);
    @(negedge clk); chk("R7", "cleared", 32'(irq), 32'h0);
    sts_wr(8'h04, 8'h00);
    @(negedge clk); chk("R7", "error raises", 32'(irq), 32'h1);
    sts_wr(8'h00, 8'h02);
    @(negedge clk); chk("R7", "ie off", 32'(irq), 32'h0);
    sts_wr(8'h00, 8'hFF);

    // R11 pause and R12 hold
    desc_wr(1'b0, 32'h9000, 8);
    mem_req_ready = 1'b0;
    sts_wr(8'h11, 8'h00);
    repeat (6) @(negedge clk);
    chk("R12", "offered", 32'(mem_req_valid), 32'h1);
    chk("R12", "addr", mem_req_addr, 32'h9000);
    sts_wr(8'h00, 8'h01);
    @(negedge clk); chk("R12", "held after run off", 32'(mem_req_valid), 32'h1);
    @(posedge clk); #1 mem_req_ready = 1'b1;
    @(posedge clk); #1 mem_req_ready = 1'b0;
    @(negedge clk);
    chk("R11", "no new request", 32'(mem_req_valid), 32'h0);
    chk("R11", "count after one", 32'(count_a), 32'd7);
    repeat (10) @(negedge clk);
    chk("R11", "still paused", 32'(mem_req_valid), 32'h0);
    chk("R11", "count kept", 32'(count_a), 32'd7);
    mem_req_ready = 1'b1;
    sts_wr(8'h01, 8'h00);
    wait_idle();
    chk("R11", "resumed count", 32'(count_a), 32'h0);
    chk("R11", "resumed status", 32'(sts_q), 32'h89);

    report();
  end
endmodule